// File: doc/BRIEF.md
# GPIO Port Register Block

This block is the register file behind one 16-pin general-purpose I/O port. A processor reaches it over a plain word-addressed bus that has a write strobe and a combinational read path. Each pin has five configuration fields: its direction mode, driver type, edge speed, pull resistor and alternate-function index. The block turns them into per-pin pad controls: drive enable, drive value, open-drain select, pull-up and pull-down enables, an alternate-function enable, and a 4-bit index for an external function multiplexer.

Output data can be written whole. It can also be changed through a 32-bit set/clear register, so software never needs a read-modify-write to flip single pins. Pad inputs pass through a two-flop synchronizer before they can be read. A lock vector from outside freezes the configuration fields of chosen pins.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every configuration field and the output data read as zero. All pins are inputs with no pull, no drive, no open-drain and no alternate function.
- R2: Mode field encoding is 00 input, 01 output, 10 alternate function, 11 analog. pad_oe[n] is 1 for modes 01 and 10. pad_af_en[n] is 1 only for mode 10.
- R3: Bit n of the driver-type register selects open-drain (1) or push-pull (0). pad_od[n] is 1 only when that bit is set and the pin is driven.
- R4: Mode, speed and pull fields are 2 bits wide at bit 2n. Pull code 01 enables pull-up, 10 enables pull-down, and 00 or 11 enables neither.
- R5: In analog mode a pin's pull field has no effect: both pull enables stay 0.
- R6: Alternate-function index of pin n is a 4-bit nibble at bit (n mod 8)*4. Pins 0-7 sit at address 7 and pins 8-15 at address 8. It appears on pad_af_sel[4n+3:4n].
- R7: A write to address 6 sets pin n's output for a 1 in bit n (15:0) and clears it for a 1 in bit n+16. The new value shows on pad_out after the clock edge that takes the write. Address 6 reads zero.
- R8: If a single write to address 6 both sets and clears the same pin, the pin ends up set.
- R9: Address 4 returns pad_in through two flops. A change on pad_in is readable after the second rising edge, and not after the first.
- R10: A write to a configuration register leaves unchanged every field of each pin whose lock_en bit is 1. Fields of unlocked pins in the same write update normally.
- R11: Word address map: 0 mode, 1 driver type, 2 speed, 3 pull, 4 input (read-only), 5 output data, 6 set/clear, 7/8 alternate function. Addresses 9-15 read zero and ignore writes.
- R12: Output data (address 5) is written and read whole, is not affected by lock_en, and drives pad_out directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| lock_en | input | 16 | Per-pin configuration lock |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Output data to the pads |
| pad_oe | output | 16 | Pad drive enable |
| pad_od | output | 16 | Open-drain select |
| pad_pull_up | output | 16 | Pull-up enable |
| pad_pull_dn | output | 16 | Pull-down enable |
| pad_af_en | output | 16 | Pin owned by the alternate-function multiplexer |
| pad_af_sel | output | 64 | Alternate-function index, 4 bits per pin |

## Verification
The bench writes one address that both sets and clears the same pins. A design with the wrong priority leaves those pins low. It also checks that the set/clear address reads zero, which catches a design that stores the written word. It drives analog mode together with a live pull code, which exposes pull enables left ungated. It samples the input register after one edge and again after two, so a synchronizer with a missing or extra stage gives the wrong value. Random writes under random lock vectors show any leak through a lock, including on the nibble-wide alternate-function fields where the pin-to-nibble mapping is easiest to get wrong.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PINS     = 16;
    localparam int BUS_W    = 32;
    localparam int REG_AW   = 4;
    localparam int AF_W     = 4;
    localparam int AF_PER_R = BUS_W / AF_W;

    typedef enum logic [1:0] {
        PM_IN  = 2'b00,
        PM_OUT = 2'b01,
        PM_ALT = 2'b10,
        PM_ANA = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        PL_NONE = 2'b00,
        PL_UP   = 2'b01,
        PL_DOWN = 2'b10,
        PL_RSVD = 2'b11
    } pull_e;

    localparam logic [REG_AW-1:0] RA_MODE   = 4'd0;
    localparam logic [REG_AW-1:0] RA_OTYPE  = 4'd1;
    localparam logic [REG_AW-1:0] RA_SPEED  = 4'd2;
    localparam logic [REG_AW-1:0] RA_PULL   = 4'd3;
    localparam logic [REG_AW-1:0] RA_IN     = 4'd4;
    localparam logic [REG_AW-1:0] RA_OUT    = 4'd5;
    localparam logic [REG_AW-1:0] RA_SETCLR = 4'd6;
    localparam logic [REG_AW-1:0] RA_AFLO   = 4'd7;
    localparam logic [REG_AW-1:0] RA_AFHI   = 4'd8;

    typedef struct packed {
        pin_mode_e       mode;
        logic            otype;
        logic [1:0]      speed;
        pull_e           pull;
        logic [AF_W-1:0] af;
    } pin_cfg_t;

    typedef struct packed {
        logic mode;
        logic otype;
        logic speed;
        logic pull;
        logic af;
    } cfg_we_t;

    function automatic logic drives(pin_mode_e m);
        return (m == PM_OUT) || (m == PM_ALT);
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
    import gpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cfg_we_t  we,
    input  logic     locked,
    input  pin_cfg_t wr,
    output pin_cfg_t cfg
);
    pin_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: PM_IN, otype: 1'b0, speed: 2'b00, pull: PL_NONE, af: '0};
        end else if (!locked) begin
            if (we.mode)  cfg_q.mode  <= wr.mode;
            if (we.otype) cfg_q.otype <= wr.otype;
            if (we.speed) cfg_q.speed <= wr.speed;
            if (we.pull)  cfg_q.pull  <= wr.pull;
            if (we.af)    cfg_q.af    <= wr.af;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_whole,
    input  logic               wr_setclr,
    input  logic [2*WIDTH-1:0] wdata,
    output logic [WIDTH-1:0]   odr
);
    logic [WIDTH-1:0] odr_q;
    logic [WIDTH-1:0] set_bits, clr_bits;

    assign set_bits = wdata[WIDTH-1:0];
    assign clr_bits = wdata[2*WIDTH-1:WIDTH];

    always_ff @(posedge clk) begin
        if (rst)            odr_q <= '0;
        else if (wr_whole)  odr_q <= set_bits;
        else if (wr_setclr) odr_q <= (odr_q & ~clr_bits) | set_bits;
    end

    assign odr = odr_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_we,
    input  logic [REG_AW-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic [PINS-1:0]       lock_en,
    input  logic [PINS-1:0]       pad_in,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe,
    output logic [PINS-1:0]       pad_od,
    output logic [PINS-1:0]       pad_pull_up,
    output logic [PINS-1:0]       pad_pull_dn,
    output logic [PINS-1:0]       pad_af_en,
    output logic [PINS*AF_W-1:0]  pad_af_sel
);
    localparam int PAIR_W = 2 * PINS;

    logic [PAIR_W-1:0]    mode_q, speed_q, pull_q;
    logic [PINS-1:0]      otype_q;
    logic [PINS*AF_W-1:0] af_q;
    logic [PINS-1:0]      in_sync;

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(in_sync)
    );

    gpio_out_data #(.WIDTH(PINS)) u_odr (
        .clk(clk), .rst(rst),
        .wr_whole(bus_we && bus_addr == RA_OUT),
        .wr_setclr(bus_we && bus_addr == RA_SETCLR),
        .wdata(bus_wdata), .odr(pad_out)
    );

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        localparam int AF_OFS = (n % AF_PER_R) * AF_W;
        localparam logic [REG_AW-1:0] AF_ADDR = (n < AF_PER_R) ? RA_AFLO : RA_AFHI;
        cfg_we_t  we;
        pin_cfg_t wr;
        pin_cfg_t cfg;

        assign we.mode  = bus_we && bus_addr == RA_MODE;
        assign we.otype = bus_we && bus_addr == RA_OTYPE;
        assign we.speed = bus_we && bus_addr == RA_SPEED;
        assign we.pull  = bus_we && bus_addr == RA_PULL;
        assign we.af    = bus_we && bus_addr == AF_ADDR;

        assign wr.mode  = pin_mode_e'(bus_wdata[2*n +: 2]);
        assign wr.otype = bus_wdata[n];
        assign wr.speed = bus_wdata[2*n +: 2];
        assign wr.pull  = pull_e'(bus_wdata[2*n +: 2]);
        assign wr.af    = bus_wdata[AF_OFS +: AF_W];

        gpio_pin_cfg u_cfg (
            .clk(clk), .rst(rst), .we(we), .locked(lock_en[n]), .wr(wr), .cfg(cfg)
        );

        assign mode_q[2*n +: 2]      = cfg.mode;
        assign otype_q[n]            = cfg.otype;
        assign speed_q[2*n +: 2]     = cfg.speed;
        assign pull_q[2*n +: 2]      = cfg.pull;
        assign af_q[AF_W*n +: AF_W]  = cfg.af;

        assign pad_oe[n]      = drives(cfg.mode);
        assign pad_od[n]      = drives(cfg.mode) && cfg.otype;
        assign pad_af_en[n]   = cfg.mode == PM_ALT;
        assign pad_pull_up[n] = cfg.mode != PM_ANA && cfg.pull == PL_UP;
        assign pad_pull_dn[n] = cfg.mode != PM_ANA && cfg.pull == PL_DOWN;
        assign pad_af_sel[AF_W*n +: AF_W] = cfg.af;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_MODE:  bus_rdata = mode_q;
            RA_OTYPE: bus_rdata[PINS-1:0] = otype_q;
            RA_SPEED: bus_rdata = speed_q;
            RA_PULL:  bus_rdata = pull_q;
            RA_IN:    bus_rdata[PINS-1:0] = in_sync;
            RA_OUT:   bus_rdata[PINS-1:0] = pad_out;
            RA_AFLO:  bus_rdata = af_q[BUS_W-1:0];
            RA_AFHI:  bus_rdata = af_q[2*BUS_W-1:BUS_W];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [15:0] lock_en,
    input logic [15:0] otype_q,
    input logic [15:0] pad_out,
    input logic [15:0] pad_oe,
    input logic [15:0] pad_od,
    input logic [15:0] pad_af_en,
    input logic [15:0] pad_pull_up,
    input logic [15:0] pad_pull_dn
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $fell(rst) |-> (pad_oe == '0 && pad_af_en == '0 && pad_out == '0));

    // R2
    af_drives_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_af_en & ~pad_oe) == '0);

    // R3
    od_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_od & ~pad_oe) == '0);

    // R4
    pull_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_pull_up & pad_pull_dn) == '0);

    // R7
    setclr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr == 4'd6 |-> bus_rdata == '0);

    // R8
    setclr_apply_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 4'd6) |=>
        pad_out == (($past(pad_out) & ~$past(bus_wdata[31:16])) | $past(bus_wdata[15:0])));

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((otype_q ^ $past(otype_q)) & $past(lock_en)) == '0);
endmodule

bind gpio_port_regs gpio_port_chk u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_en(lock_en),
    .otype_q(otype_q), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .pad_af_en(pad_af_en), .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
);

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] lock_en = '0;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_od, pad_pull_up, pad_pull_dn, pad_af_en;
    logic [63:0] pad_af_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_mode, m_speed, m_pull, m_aflo, m_afhi;
    logic [15:0] m_ot, m_odr, m_in;

    always #5 clk = ~clk;

    gpio_port_regs u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_en(lock_en),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
        .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
        .pad_af_en(pad_af_en), .pad_af_sel(pad_af_sel)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp2(input logic [15:0] l);
        logic [31:0] r;
        for (int i = 0; i < 16; i++) r[2*i +: 2] = {2{l[i]}};
        return r;
    endfunction

    function automatic logic [31:0] exp4(input logic [7:0] l);
        logic [31:0] r;
        for (int i = 0; i < 8; i++) r[4*i +: 4] = {4{l[i]}};
        return r;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return m_mode;
            4'd1: return {16'h0, m_ot};
            4'd2: return m_speed;
            4'd3: return m_pull;
            4'd4: return {16'h0, m_in};
            4'd5: return {16'h0, m_odr};
            4'd7: return m_aflo;
            4'd8: return m_afhi;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] k2;
        k2 = exp2(lock_en);
        case (a)
            4'd0: m_mode  = (m_mode & k2) | (d & ~k2);
            4'd1: m_ot    = (m_ot & lock_en) | (d[15:0] & ~lock_en);
            4'd2: m_speed = (m_speed & k2) | (d & ~k2);
            4'd3: m_pull  = (m_pull & k2) | (d & ~k2);
            4'd5: m_odr   = d[15:0];
            4'd6: m_odr   = (m_odr & ~d[31:16]) | d[15:0];
            4'd7: m_aflo  = (m_aflo & exp4(lock_en[7:0])) | (d & ~exp4(lock_en[7:0]));
            4'd8: m_afhi  = (m_afhi & exp4(lock_en[15:8])) | (d & ~exp4(lock_en[15:8]));
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        model_write(a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_check(input logic [3:0] a, input string req);
        bus_addr = a;
        #1;
        check({32'h0, bus_rdata}, {32'h0, model_read(a)}, req);
    endtask

    task automatic pads_check();
        logic [15:0] e_oe, e_od, e_up, e_dn, e_af;
        logic [1:0]  md, pl;
        for (int i = 0; i < 16; i++) begin
            md = m_mode[2*i +: 2];
            pl = m_pull[2*i +: 2];
            e_oe[i] = (md == 2'b01) || (md == 2'b10);
            e_od[i] = e_oe[i] && m_ot[i];
            e_af[i] = md == 2'b10;
            e_up[i] = md != 2'b11 && pl == 2'b01;
            e_dn[i] = md != 2'b11 && pl == 2'b10;
        end
        #1;
        check({48'h0, pad_oe}, {48'h0, e_oe}, "R2 oe");
        check({48'h0, pad_af_en}, {48'h0, e_af}, "R2 af_en");
        check({48'h0, pad_od}, {48'h0, e_od}, "R3 od");
        check({32'h0, pad_pull_up, pad_pull_dn}, {32'h0, e_up, e_dn}, "R4/R5 pulls");
        check(pad_af_sel, {m_afhi, m_aflo}, "R6 af_sel");
        check({48'h0, pad_out}, {48'h0, m_odr}, "R12 pad_out");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [3:0] addrs [8] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd8};
        void'($urandom(32'd1234));
        {m_mode, m_speed, m_pull, m_aflo, m_afhi} = '0;
        {m_ot, m_odr, m_in} = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 9; a++) read_check(4'(a), "R1 reset readback");
        pads_check();

        // R2 R3 R6 directed: mixed modes
        bus_write(4'd0, 32'hE4E4_E4E4);
        bus_write(4'd1, 32'h0000_F0F0);
        bus_write(4'd7, 32'h7654_3210);
        bus_write(4'd8, 32'hFEDC_BA98);
        pads_check();
        check({60'h0, pad_af_sel[4*9 +: 4]}, 64'h9, "R6 pin9 nibble");

        // R4 R5 pull in analog vs input mode
        bus_write(4'd3, 32'h5555_5555);
        bus_write(4'd0, 32'hFFFF_FFFF);
        #1 check({48'h0, pad_pull_up}, 64'h0, "R5 analog no pull");
        bus_write(4'd0, 32'h0000_0000);
        #1 check({48'h0, pad_pull_up}, 64'hFFFF, "R4 pull-up");
        bus_write(4'd3, 32'hAAAA_AAAA);
        #1 check({48'h0, pad_pull_dn}, 64'hFFFF, "R4 pull-down");

        // R7 set/clear and read zero
        bus_write(4'd5, 32'h0000_00F0);
        bus_write(4'd6, 32'h0030_0003);
        #1 check({48'h0, pad_out}, 64'h00C3, "R7 set/clear");
        read_check(4'd6, "R7 reads zero");
        // R8 set wins
        bus_write(4'd6, 32'h00C1_00C1);
        #1 check({48'h0, pad_out}, 64'h00C3, "R8 set priority");

        // R9 two-stage input sync
        @(negedge clk); pad_in = 16'hA5C3;
        @(negedge clk); bus_addr = 4'd4; #1;
        check({32'h0, bus_rdata}, 64'h0, "R9 not after one edge");
        @(negedge clk); #1;
        check({32'h0, bus_rdata}, 64'hA5C3, "R9 after two edges");
        m_in = 16'hA5C3;

        // R10 lock: full lock then partial lock
        lock_en = 16'hFFFF;
        bus_write(4'd0, 32'h5555_5555);
        bus_write(4'd8, 32'h1111_1111);
        read_check(4'd0, "R10 locked mode");
        read_check(4'd8, "R10 locked af hi");
        lock_en = 16'h00FF;
        bus_write(4'd1, 32'h0000_FFFF);
        read_check(4'd1, "R10 partial lock otype");
        bus_write(4'd5, 32'h0000_1234);
        read_check(4'd5, "R12 odr ignores lock");

        // R11 unmapped addresses
        bus_write(4'd12, 32'hFFFF_FFFF);
        for (int a = 9; a < 16; a++) read_check(4'(a), "R11 unmapped zero");
        pads_check();

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [3:0] a;
            a = addrs[$urandom_range(0, 7)];
            lock_en = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
            bus_write(a, $urandom);
            read_check(a, "R10/R11 random readback");
            if (it % 8 == 0) pads_check();
        end
        lock_en = '0;
        for (int a = 0; a < 9; a++) read_check(4'(a), "R11 final readback");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule